// File: doc/BRIEF.md
# Destination Address Screen

This block sits on the receive side of an Ethernet MAC and decides whether a frame is wanted, looking only at its destination address. The address bytes arrive one per cycle on a byte stream whose first byte carries a start marker. While they arrive, every enabled entry of a small content-addressable table is compared with them in parallel. When the sixth byte has been taken, the block gives a verdict: accept or reject, plus a multicast or broadcast flag when one of those checks decided the outcome.

Four checks are tried in a fixed order of priority. Promiscuous mode comes first, then accept-all-group, then broadcast, then the table. The first check that passes decides. Promiscuous mode admits only individual (unicast) destinations. A group destination under promiscuous mode falls through to the later checks. The table is written one 16-bit word at a time. It can be read back through three 16-bit windows, but only while the owning controller reports that it is in reset mode.

Top module: `rx_addr_screen`

## Requirements
- R1: Precedence. The checks run in this order: promiscuous, accept-all-group, broadcast, table. The first one that passes sets the verdict. For example, with both accept-all-group and broadcast enabled, an all-0xFF destination is flagged multicast and not broadcast.
- R2: With `cfg_promisc` high, a destination whose first byte has bit 0 clear is accepted with both flags low. A destination whose first byte has bit 0 set is not admitted by this check.
- R3: With `cfg_all_group` high, a destination whose first byte has bit 0 set is accepted with `dec_mcast` high.
- R4: With `cfg_bcast_ok` high, a destination of six 0xFF bytes is accepted with `dec_bcast` high, unless an earlier check decided.
- R5: Table entry i takes part in matching only while bit i of the enable mask is set. A match on all six bytes accepts the frame with both flags low.
- R6: A frame that passes no check gives `dec_valid` high with `dec_accept`, `dec_mcast` and `dec_bcast` all low.
- R7: When `tbl_wr_en` is high, word w (0..2) of entry `tbl_wr_sel` is written. Bits [7:0] go to byte 2w and bits [15:8] go to byte 2w+1; byte 0 is the first byte of the stream. A word index of 3 changes nothing. When `tbl_mask_wr` is high, `tbl_wr_data` becomes the enable mask.
- R8: `rb_data` shows the entry selected by `rb_ptr[3:0]`. Window 0 gives {byte5,byte4}, window 1 gives {byte3,byte2}, window 2 gives {byte1,byte0}, and window 3 gives zero. `rb_data` is zero whenever `ctl_reset_mode` is low.
- R9: The verdict appears in the cycle after the sixth byte is taken. Bytes after the sixth are ignored. The outputs hold until a start-marked byte is taken; from the next cycle on, all four decision outputs are low.
- R10: After reset the decision outputs are low, and every table entry and the enable mask are zero.
- R11: A table or mask write in the same cycle as a compared byte takes effect after that compare. The byte is judged against the contents held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_promisc | input | 1 | Promiscuous check enable |
| cfg_all_group | input | 1 | Accept-all-group check enable |
| cfg_bcast_ok | input | 1 | Broadcast check enable |
| ctl_reset_mode | input | 1 | Controller is in reset mode (opens readback) |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_sel | input | 4 | Entry written |
| tbl_wr_word | input | 2 | Word of the entry written (0..2) |
| tbl_mask_wr | input | 1 | Enable mask write strobe |
| tbl_wr_data | input | 16 | Write data for a word or the mask |
| rb_ptr | input | 16 | Readback entry pointer; low 4 bits used |
| rb_win | input | 2 | Readback window select |
| rb_data | output | 16 | Readback word |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | Marks the first destination byte |
| rx_byte | input | 8 | Destination byte |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Frame accepted |
| dec_mcast | output | 1 | Accepted by the group check |
| dec_bcast | output | 1 | Accepted by the broadcast check |

## Verification
Table maintenance and matching can fall in the same cycle. A word write to an entry can land on the very edge at which the entry's bytes are compared with an arriving byte. The bench provokes this by rewriting the last word of a matching entry in the cycle the sixth byte is presented. The expected result is acceptance on the old contents, followed by rejection of the same address in the next frame. A reference model that applies writes after comparing, edge by edge, also judges every other cycle, including readback in that cycle.

// File: rtl/rx_screen_pkg.sv
package rx_screen_pkg;
   typedef struct packed {
      logic accept;
      logic mcast;
      logic bcast;
   } verdict_t;

   localparam int unsigned WORD_W = 16;
   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/screen_table.sv
module screen_table
   import rx_screen_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned ABYTES  = 6,
   parameter int unsigned PTR_W   = 16,
   localparam int unsigned EIDX_W = $clog2(ENTRIES),
   localparam int unsigned WORDS  = ABYTES / 2,
   localparam int unsigned WSEL_W = (WORDS < 2) ? 1 : $clog2(WORDS + 1),
   localparam int unsigned ENT_W  = ABYTES * BYTE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [EIDX_W-1:0]         wr_sel,
   input  logic [WSEL_W-1:0]         wr_word,
   input  logic                      mask_wr,
   input  logic [WORD_W-1:0]         wr_data,
   input  logic [PTR_W-1:0]          rd_ptr,
   input  logic [WSEL_W-1:0]         rd_win,
   input  logic                      rd_open,
   output logic [WORD_W-1:0]         rd_data,
   output logic [ENTRIES*ENT_W-1:0]  tbl_flat,
   output logic [ENTRIES-1:0]        mask
);
   logic [ENT_W-1:0] ent_q [ENTRIES];
   logic             word_ok;

   assign word_ok = int'(wr_word) < int'(WORDS);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[e] <= '0;
         end else if (wr_en && word_ok && (int'(wr_sel) == e)) begin
            ent_q[e][int'(wr_word)*WORD_W +: WORD_W] <= wr_data;
         end
      end
      assign tbl_flat[e*ENT_W +: ENT_W] = ent_q[e];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_wr) mask <= wr_data[ENTRIES-1:0];
   end

   logic [ENT_W-1:0] rd_ent;
   int               rd_word;
   assign rd_ent  = ent_q[rd_ptr[EIDX_W-1:0]];
   assign rd_word = int'(WORDS) - 1 - int'(rd_win);

   always_comb begin
      rd_data = '0;
      if (rd_open && (int'(rd_win) < int'(WORDS)))
         rd_data = rd_ent[rd_word*WORD_W +: WORD_W];
   end

   // R7: a write with an out-of-range word index leaves the readback of that entry unchanged
   a_r7_bad_word_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !word_ok && !mask_wr && rd_open && $stable(rd_ptr) && $stable(rd_win))
      |=> $stable(rd_data) || !rd_open || !$stable(rd_ptr) || !$stable(rd_win));
endmodule

// File: rtl/screen_match.sv
module screen_match
   import rx_screen_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned ABYTES  = 6,
   localparam int unsigned ENT_W  = ABYTES * BYTE_W,
   localparam int unsigned CNT_W  = $clog2(ABYTES + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rx_valid,
   input  logic                     rx_sof,
   input  logic [BYTE_W-1:0]        rx_byte,
   input  logic [ENTRIES*ENT_W-1:0] tbl_flat,
   input  logic [ENTRIES-1:0]       mask,
   output logic                     fin,
   output logic                     sof_take,
   output logic                     grp_bit,
   output logic                     all_ones,
   output logic                     cam_hit
);
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   pos;
   logic               take;
   logic [ENTRIES-1:0] live_q, live_nxt;
   logic               grp_q, ones_q;

   assign pos      = rx_sof ? '0 : cnt_q;
   assign take     = rx_valid && (rx_sof || (int'(cnt_q) < int'(ABYTES)));
   assign sof_take = rx_valid && rx_sof;
   assign fin      = take && (int'(pos) == int'(ABYTES) - 1);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic byte_eq;
      assign byte_eq     = tbl_flat[e*ENT_W + int'(pos)*BYTE_W +: BYTE_W] == rx_byte;
      assign live_nxt[e] = byte_eq && (rx_sof || live_q[e]);
   end

   assign grp_bit  = rx_sof ? rx_byte[0] : grp_q;
   assign all_ones = (rx_sof || ones_q) && (&rx_byte);
   assign cam_hit  = |(live_nxt & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_W'(ABYTES);
         live_q <= '0;
         grp_q  <= 1'b0;
         ones_q <= 1'b0;
      end else if (take) begin
         cnt_q  <= pos + 1'b1;
         live_q <= live_nxt;
         grp_q  <= grp_bit;
         ones_q <= all_ones;
      end
   end

   // R9: a byte past the sixth never ends a frame a second time
   a_r9_single_finish: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);
endmodule

// File: rtl/screen_verdict.sv
module screen_verdict
   import rx_screen_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_promisc,
   input  logic     cfg_all_group,
   input  logic     cfg_bcast_ok,
   input  logic     fin,
   input  logic     sof_take,
   input  logic     grp_bit,
   input  logic     all_ones,
   input  logic     cam_hit,
   output logic     dec_valid,
   output verdict_t dec
);
   verdict_t nxt;

   always_comb begin
      nxt = '0;
      if (cfg_promisc && !grp_bit)        nxt.accept = 1'b1;
      else if (cfg_all_group && grp_bit)  begin nxt.accept = 1'b1; nxt.mcast = 1'b1; end
      else if (cfg_bcast_ok && all_ones)  begin nxt.accept = 1'b1; nxt.bcast = 1'b1; end
      else if (cam_hit)                   nxt.accept = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec       <= '0;
      end else if (fin) begin
         dec_valid <= 1'b1;
         dec       <= nxt;
      end else if (sof_take) begin
         dec_valid <= 1'b0;
         dec       <= '0;
      end
   end

   a_r2_promisc_unicast: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && cfg_promisc && !grp_bit) |=> (dec_accept_w && !dec.mcast && !dec.bcast));
   a_r3_group_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && cfg_all_group && grp_bit) |=> (dec.accept && dec.mcast && !dec.bcast));
   a_r1_flags_need_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.mcast || dec.bcast) |-> (dec.accept && dec_valid));
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !sof_take) |=> (dec_valid && $stable(dec)));
   a_r9_rise_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> $past(fin));

   logic dec_accept_w;
   assign dec_accept_w = dec.accept;
endmodule

// File: rtl/rx_addr_screen.sv
module rx_addr_screen
   import rx_screen_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned ABYTES  = 6,
   parameter int unsigned PTR_W   = 16,
   localparam int unsigned EIDX_W = $clog2(ENTRIES),
   localparam int unsigned WORDS  = ABYTES / 2,
   localparam int unsigned WSEL_W = (WORDS < 2) ? 1 : $clog2(WORDS + 1),
   localparam int unsigned ENT_W  = ABYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_promisc,
   input  logic              cfg_all_group,
   input  logic              cfg_bcast_ok,
   input  logic              ctl_reset_mode,
   input  logic              tbl_wr_en,
   input  logic [EIDX_W-1:0] tbl_wr_sel,
   input  logic [WSEL_W-1:0] tbl_wr_word,
   input  logic              tbl_mask_wr,
   input  logic [15:0]       tbl_wr_data,
   input  logic [PTR_W-1:0]  rb_ptr,
   input  logic [WSEL_W-1:0] rb_win,
   output logic [15:0]       rb_data,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_byte,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic              dec_mcast,
   output logic              dec_bcast
);
   if ((ABYTES < 2) || (ABYTES % 2 != 0)) begin : g_bad_abytes
      $error("ABYTES must be even and at least 2");
   end
   if ((1 << EIDX_W) != ENTRIES || ENTRIES > 16) begin : g_bad_entries
      $error("ENTRIES must be a power of two no larger than the mask word");
   end
   if (PTR_W < EIDX_W) begin : g_bad_ptr
      $error("PTR_W too narrow for the entry index");
   end

   logic [ENTRIES*ENT_W-1:0] tbl_flat;
   logic [ENTRIES-1:0]       mask;
   logic                     fin, sof_take, grp_bit, all_ones, cam_hit;
   verdict_t                 dec;

   screen_table #(.ENTRIES(ENTRIES), .ABYTES(ABYTES), .PTR_W(PTR_W)) u_table (
      .clk, .rst_n,
      .wr_en(tbl_wr_en), .wr_sel(tbl_wr_sel), .wr_word(tbl_wr_word),
      .mask_wr(tbl_mask_wr), .wr_data(tbl_wr_data),
      .rd_ptr(rb_ptr), .rd_win(rb_win), .rd_open(ctl_reset_mode), .rd_data(rb_data),
      .tbl_flat, .mask
   );

   screen_match #(.ENTRIES(ENTRIES), .ABYTES(ABYTES)) u_match (
      .clk, .rst_n, .rx_valid, .rx_sof, .rx_byte, .tbl_flat, .mask,
      .fin, .sof_take, .grp_bit, .all_ones, .cam_hit
   );

   screen_verdict u_verdict (
      .clk, .rst_n, .cfg_promisc, .cfg_all_group, .cfg_bcast_ok,
      .fin, .sof_take, .grp_bit, .all_ones, .cam_hit,
      .dec_valid, .dec
   );

   assign dec_accept = dec.accept;
   assign dec_mcast  = dec.mcast;
   assign dec_bcast  = dec.bcast;

   // R8: readback stays closed outside reset mode
   a_r8_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_reset_mode |-> (rb_data == 16'h0000));
   // R6: a verdict that is not an accept carries no flag
   a_r6_reject_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_accept) |-> (!dec_mcast && !dec_bcast));
endmodule

// File: tb/test_rx_addr_screen.sv
module test_rx_addr_screen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_promisc = 0, cfg_all_group = 0, cfg_bcast_ok = 0, ctl_reset_mode = 0;
   logic        tbl_wr_en = 0, tbl_mask_wr = 0;
   logic [3:0]  tbl_wr_sel = 0;
   logic [1:0]  tbl_wr_word = 0;
   logic [15:0] tbl_wr_data = 0;
   logic [15:0] rb_ptr = 0;
   logic [1:0]  rb_win = 0;
   logic [15:0] rb_data;
   logic        rx_valid = 0, rx_sof = 0;
   logic [7:0]  rx_byte = 0;
   logic        dec_valid, dec_accept, dec_mcast, dec_bcast;

   int    checks = 0, errors = 0;
   string tag = "R10";
   bit    live_cmp = 0;

   always #4 clk = ~clk;

   rx_addr_screen i_rx_addr_screen (.*);

   // reference model state
   byte unsigned m_cam [16][6];
   logic [15:0]  m_mask;
   byte unsigned m_buf [6];
   bit           m_live [16];
   int           m_cnt;
   bit           e_valid, e_acc, e_mc, e_bc;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_cam[i, j]) m_cam[i][j] = 0;
         m_mask = 0; m_cnt = 6;
         e_valid = 0; e_acc = 0; e_mc = 0; e_bc = 0;
      end else begin
         int p;
         p = -1;
         if (rx_valid) begin
            if (rx_sof) p = 0;
            else if (m_cnt < 6) p = m_cnt;
         end
         if (p >= 0) begin
            m_buf[p] = rx_byte;
            for (int e = 0; e < 16; e++)
               m_live[e] = (m_cam[e][p] == rx_byte) && (p == 0 || m_live[e]);
            m_cnt = p + 1;
            if (p == 0) begin e_valid = 0; e_acc = 0; e_mc = 0; e_bc = 0; end
            if (p == 5) begin
               bit grp, ff, hit;
               grp = m_buf[0][0];
               ff = 1; hit = 0;
               for (int k = 0; k < 6; k++) if (m_buf[k] != 8'hFF) ff = 0;
               for (int e = 0; e < 16; e++) if (m_live[e] && m_mask[e]) hit = 1;
               e_valid = 1; e_acc = 0; e_mc = 0; e_bc = 0;
               if (cfg_promisc && !grp) e_acc = 1;
               else if (cfg_all_group && grp) begin e_acc = 1; e_mc = 1; end
               else if (cfg_bcast_ok && ff) begin e_acc = 1; e_bc = 1; end
               else if (hit) e_acc = 1;
            end
         end
         if (tbl_wr_en && tbl_wr_word < 3) begin
            m_cam[tbl_wr_sel][2*tbl_wr_word]   = tbl_wr_data[7:0];
            m_cam[tbl_wr_sel][2*tbl_wr_word+1] = tbl_wr_data[15:8];
         end
         if (tbl_mask_wr) m_mask = tbl_wr_data;
      end
   end

   task automatic chk(input string t, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (live_cmp) begin
         logic [15:0] erb;
         int w, ent;
         #1;
         ent = int'(rb_ptr[3:0]);
         w = int'(rb_win);
         erb = 16'h0;
         if (ctl_reset_mode && w < 3) erb = {m_cam[ent][2*(2-w)+1], m_cam[ent][2*(2-w)]};
         chk(tag, "valid", {15'b0, dec_valid}, {15'b0, e_valid});
         chk(tag, "accept", {15'b0, dec_accept}, {15'b0, e_acc});
         chk(tag, "mcast", {15'b0, dec_mcast}, {15'b0, e_mc});
         chk(tag, "bcast", {15'b0, dec_bcast}, {15'b0, e_bc});
         chk(tag, "rb_data", rb_data, erb);
      end
   end

   task automatic tw(input logic [3:0] e, input logic [1:0] w, input logic [15:0] d);
      @(negedge clk);
      tbl_wr_en = 1; tbl_wr_sel = e; tbl_wr_word = w; tbl_wr_data = d;
      @(negedge clk);
      tbl_wr_en = 0;
   endtask

   task automatic mw(input logic [15:0] d);
      @(negedge clk);
      tbl_mask_wr = 1; tbl_wr_data = d;
      @(negedge clk);
      tbl_mask_wr = 0;
   endtask

   task automatic frame(input logic [47:0] a, input int extra, input bit late_wr, input logic [15:0] late_d);
      for (int k = 0; k < 6 + extra; k++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = (k == 0);
         rx_byte = (k < 6) ? a[k*8 +: 8] : 8'h5A;
         tbl_wr_en = (late_wr && k == 5);
         tbl_wr_sel = 0; tbl_wr_word = 2; tbl_wr_data = late_d;
         if (k == 1) begin
            #1; chk("R9", "valid low after start", {15'b0, dec_valid}, 16'h0);
         end
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; tbl_wr_en = 0;
      #1;
   endtask

   task automatic expect_dec(input string t, input bit a, input bit m, input bit b);
      chk(t, "valid", {15'b0, dec_valid}, 16'h1);
      chk(t, "accept", {15'b0, dec_accept}, {15'b0, a});
      chk(t, "mcast", {15'b0, dec_mcast}, {15'b0, m});
      chk(t, "bcast", {15'b0, dec_bcast}, {15'b0, b});
   endtask

   task automatic rb(input logic [15:0] p, input logic [1:0] w, input logic [15:0] exp, input string t);
      @(negedge clk);
      rb_ptr = p; rb_win = w;
      #1; chk(t, "readback", rb_data, exp);
   endtask

   localparam logic [47:0] A_E0  = 48'h5544_3322_1102; // 02:11:22:33:44:55
   localparam logic [47:0] A_E5  = 48'hEEDD_CCBB_AA00; // 00:AA:BB:CC:DD:EE
   localparam logic [47:0] A_UNI = 48'h0000_0000_0004;
   localparam logic [47:0] A_GRP = 48'h0100_005E_0001;
   localparam logic [47:0] A_BC  = 48'hFFFF_FFFF_FFFF;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      tag = "R10";
      chk("R10", "reset valid", {15'b0, dec_valid}, 16'h0);
      chk("R10", "reset accept", {15'b0, dec_accept}, 16'h0);
      live_cmp = 1;
      ctl_reset_mode = 1;
      rb(16'h0003, 2'd1, 16'h0000, "R10");

      tag = "R7";
      tw(0, 0, 16'h1102); tw(0, 1, 16'h3322); tw(0, 2, 16'h5544);
      tw(0, 3, 16'hDEAD);
      tw(5, 0, 16'hAA00); tw(5, 1, 16'hCCBB); tw(5, 2, 16'hEEDD);
      mw(16'h0001);

      tag = "R8";
      rb(16'hA5F0, 2'd0, 16'h5544, "R8");
      rb(16'hA5F0, 2'd1, 16'h3322, "R8");
      rb(16'hA5F0, 2'd2, 16'h1102, "R7");
      rb(16'hA5F0, 2'd3, 16'h0000, "R8");
      rb(16'h0005, 2'd2, 16'hAA00, "R7");
      @(negedge clk); ctl_reset_mode = 0;
      rb(16'h0005, 2'd0, 16'h0000, "R8");

      tag = "R5"; frame(A_E0, 0, 0, 0); expect_dec("R5", 1, 0, 0);
      tag = "R5"; frame(A_E5, 0, 0, 0); expect_dec("R5", 0, 0, 0);
      tag = "R6"; frame(48'h5644_3322_1102, 0, 0, 0); expect_dec("R6", 0, 0, 0);
      mw(16'h0021);
      tag = "R5"; frame(A_E5, 0, 0, 0); expect_dec("R5", 1, 0, 0);

      @(negedge clk); cfg_promisc = 1;
      tag = "R2"; frame(A_UNI, 0, 0, 0); expect_dec("R2", 1, 0, 0);
      tag = "R2"; frame(A_GRP, 0, 0, 0); expect_dec("R2", 0, 0, 0);
      @(negedge clk); cfg_bcast_ok = 1;
      tag = "R4"; frame(A_BC, 0, 0, 0); expect_dec("R4", 1, 0, 1);
      @(negedge clk); cfg_promisc = 0; cfg_all_group = 1;
      tag = "R3"; frame(A_GRP, 0, 0, 0); expect_dec("R3", 1, 1, 0);
      tag = "R1"; frame(A_BC, 0, 0, 0); expect_dec("R1", 1, 1, 0);
      @(negedge clk); cfg_all_group = 0;
      tag = "R4"; frame(A_BC, 0, 0, 0); expect_dec("R4", 1, 0, 1);
      @(negedge clk); cfg_bcast_ok = 0;
      tag = "R6"; frame(A_BC, 0, 0, 0); expect_dec("R6", 0, 0, 0);

      tag = "R9"; frame(A_E0, 4, 0, 0); expect_dec("R9", 1, 0, 0);
      repeat (5) @(negedge clk);
      #1; expect_dec("R9", 1, 0, 0);

      tag = "R11"; frame(A_E0, 0, 1, 16'h9988); expect_dec("R11", 1, 0, 0);
      tag = "R11"; frame(A_E0, 0, 0, 0); expect_dec("R11", 0, 0, 0);
      @(negedge clk); ctl_reset_mode = 1;
      rb(16'h0000, 2'd0, 16'h9988, "R11");

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule